// File: doc/BRIEF.md
# Low-Power Halt Mode Controller

This block moves a small CPU core between normal running and two stopped states. A halt request strobe comes from the instruction decoder. When it arrives, a select bit picks the state: full halt, where every clock enable drops, or active halt, where the main oscillator and the timebase counter keep running so that a timebase interrupt can wake the core later.

Each wake path has its own timing:

- **Interrupt wake from active halt** returns the core to running on the next cycle, with no settling wait.
- **Reset wake from active halt**, and **any wake from full halt**, first pass through a stabilization wait of 256 or 4096 cycles. An option input picks the length. Only the oscillator runs during that wait.
- **Timebase wake from active halt** opens a guard window of the same length. If the select bit is cleared inside that window, the controller drops into full halt until the window ends, and then resumes.

The controller also does three further things:

- While in active halt it forces the interrupt mask to the enabling value.
- It requests a watchdog reset when full halt is entered with the watchdog running.
- It reports what woke it.

Top module: `lph_ctrl_top`

## Requirements
- R1: A halt request in run with `osc_sel`=0 gives full halt, with all four clock enables 0. With `osc_sel`=1 it gives active halt, with `osc_clk_en`=`tb_clk_en`=1 and `cpu_clk_en`=`per_clk_en`=0. Both take effect in the cycle after the request.
- R2: In active halt, `ext_irq` or `tb_irq` (without `rst_req`) puts the core back in run in the next cycle, with all enables 1. `cpu_release` is high for exactly that first cycle.
- R3: Waking through `rst_req` from active halt enters a stabilization wait. The wait shows `osc_clk_en`=1 and the other enables 0, and lasts 256 cycles when `long_dly`=0 and 4096 cycles when `long_dly`=1. After it, run resumes and `cpu_release` pulses.
- R4: While in active halt, `imask_force`=1 and `imask_val`=2'b10. Everywhere else `imask_force`=0 and `imask_val`=2'b00.
- R5: An interrupt already high when active halt is entered makes the controller stay in active halt for exactly one cycle before it returns to run.
- R6: `wdg_rst_req` is 1 only in full halt with `wdg_en`=1. It is never 1 in active halt.
- R7: After a `tb_irq` wake, clearing `osc_sel` before 256/4096 cycles have passed since the wake cycle drops all enables to 0 for the remainder of that period. Run resumes exactly 256/4096 cycles after the wake, with a `cpu_release` pulse.
- R8: Full halt is left only by `ext_irq` or `rst_req`, and either one goes through the R3 stabilization wait. `tb_irq` in full halt has no effect.
- R9: `wake_cause` is set on wake and encodes 0 for none, 1 for external, 2 for timebase and 3 for reset. A reset in the same cycle as an interrupt wins with cause 3, and external beats timebase.
- R10: `wake_cause` returns to 0 in the cycle after any halt entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the controller (starts in run) |
| halt_req | input | 1 | One-cycle halt instruction strobe |
| osc_sel | input | 1 | Oscillator interrupt select; 1 chooses active halt |
| ext_irq | input | 1 | External interrupt request |
| tb_irq | input | 1 | Timebase interrupt request |
| rst_req | input | 1 | Reset request used as a wake source |
| wdg_en | input | 1 | Watchdog running flag |
| long_dly | input | 1 | Delay option: 0 gives 256 cycles, 1 gives 4096 |
| osc_clk_en | output | 1 | Main oscillator enable |
| tb_clk_en | output | 1 | Timebase counter clock enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| imask_force | output | 1 | Forces the interrupt mask field |
| imask_val | output | 2 | Forced interrupt mask value |
| wdg_rst_req | output | 1 | Watchdog reset request |
| cpu_release | output | 1 | One-cycle pulse when the core is let run after a wake |
| wake_cause | output | 2 | Last wake source |

## Verification
The hardest case to reach from the ports is the full-halt remainder after a timebase wake. It needs a sequence of steps:

1. Enter active halt.
2. Pulse `tb_irq`.
3. Let the core run for a chosen number of cycles.
4. Clear `osc_sel` while the guard window is still open.

The bench does this at a known offset and checks that the idle stretch is exactly the remainder of the window. The stabilization waits are measured at the ports as the count of cycles with the CPU enable low, for both delay options. Coincident reset and interrupt, and an interrupt pending at entry, are driven in the same cycle as the strobe that matters.

// File: rtl/lph_pkg.sv
package lph_pkg;
  typedef enum logic [2:0] {
    ST_RUN   = 3'd0,
    ST_HALT  = 3'd1,
    ST_AHALT = 3'd2,
    ST_DELAY = 3'd3,
    ST_GUARD = 3'd4,
    ST_TAIL  = 3'd5
  } lph_state_e;

  typedef enum logic [1:0] {
    WK_NONE = 2'd0,
    WK_EXT  = 2'd1,
    WK_TB   = 2'd2,
    WK_RST  = 2'd3
  } wake_e;

  localparam logic [1:0] IMASK_OPEN = 2'b10;

  // terminal count of a wait of len cycles starting from zero
  function automatic int unsigned wait_last(input int unsigned len);
    return len - 1;
  endfunction

  function automatic logic is_running(input lph_state_e s);
    return (s == ST_RUN) || (s == ST_GUARD);
  endfunction

  function automatic logic is_counting(input lph_state_e s);
    return (s == ST_DELAY) || (s == ST_GUARD) || (s == ST_TAIL);
  endfunction
endpackage

// File: rtl/lph_dly_cnt.sv
module lph_dly_cnt #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned SHORT_LEN = 256,
  parameter int unsigned LONG_LEN  = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic long_sel,
  output logic done
);
  import lph_pkg::*;
  localparam logic [CNT_W-1:0] SHORT_LIM = CNT_W'(wait_last(SHORT_LEN));
  localparam logic [CNT_W-1:0] LONG_LIM  = CNT_W'(wait_last(LONG_LEN));

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] limit;

  assign limit = long_sel ? LONG_LIM : SHORT_LIM;
  assign done  = (cnt_q == limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (clr)         cnt_q <= '0;
    else if (en && !done) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/lph_fsm.sv
module lph_fsm (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                halt_req,
  input  logic                osc_sel,
  input  logic                ext_irq,
  input  logic                tb_irq,
  input  logic                rst_req,
  input  logic                dly_done,
  output lph_pkg::lph_state_e state,
  output logic [1:0]          cause,
  output logic                release_pulse,
  output logic                cnt_clr,
  output logic                cnt_en
);
  import lph_pkg::*;
  lph_state_e st_q, st_d;
  wake_e      cause_q, cause_d;
  logic       rel_q;

  always_comb begin
    st_d    = st_q;
    cause_d = cause_q;
    case (st_q)
      ST_RUN, ST_GUARD: begin
        if (halt_req) begin
          st_d    = osc_sel ? ST_AHALT : ST_HALT;
          cause_d = WK_NONE;
        end else if (st_q == ST_GUARD) begin
          if (dly_done)      st_d = ST_RUN;
          else if (!osc_sel) st_d = ST_TAIL;
        end
      end
      ST_HALT: begin
        if (rst_req) begin
          st_d = ST_DELAY; cause_d = WK_RST;
        end else if (ext_irq) begin
          st_d = ST_DELAY; cause_d = WK_EXT;
        end
      end
      ST_AHALT: begin
        if (rst_req) begin
          st_d = ST_DELAY; cause_d = WK_RST;
        end else if (ext_irq) begin
          st_d = ST_RUN;   cause_d = WK_EXT;
        end else if (tb_irq) begin
          st_d = ST_GUARD; cause_d = WK_TB;
        end
      end
      ST_DELAY, ST_TAIL: begin
        if (dly_done) st_d = ST_RUN;
      end
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_RUN;
      cause_q <= WK_NONE;
      rel_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cause_q <= cause_d;
      rel_q   <= is_running(st_d) && !is_running(st_q);
    end
  end

  assign state         = st_q;
  assign cause         = cause_q;
  assign release_pulse = rel_q;
  assign cnt_clr       = ((st_d == ST_HALT) || (st_d == ST_AHALT)) && (st_d != st_q);
  assign cnt_en        = is_counting(st_q);
endmodule

// File: rtl/lph_gate.sv
module lph_gate (
  input  lph_pkg::lph_state_e state,
  input  logic                wdg_en,
  output logic                osc_en,
  output logic                tb_en,
  output logic                cpu_en,
  output logic                per_en,
  output logic                mask_force,
  output logic [1:0]          mask_val,
  output logic                wdg_req
);
  import lph_pkg::*;
  logic run_like;
  assign run_like = is_running(state);

  always_comb begin
    osc_en = run_like || (state == ST_AHALT) || (state == ST_DELAY);
    tb_en  = run_like || (state == ST_AHALT);
    cpu_en = run_like;
    per_en = run_like;
  end

  assign mask_force = (state == ST_AHALT);
  assign mask_val   = mask_force ? IMASK_OPEN : 2'b00;
  assign wdg_req    = (state == ST_HALT) && wdg_en;
endmodule

// File: rtl/lph_ctrl_top.sv
module lph_ctrl_top #(
  parameter int unsigned CNT_W     = 12,
  parameter int unsigned SHORT_LEN = 256,
  parameter int unsigned LONG_LEN  = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       halt_req,
  input  logic       osc_sel,
  input  logic       ext_irq,
  input  logic       tb_irq,
  input  logic       rst_req,
  input  logic       wdg_en,
  input  logic       long_dly,
  output logic       osc_clk_en,
  output logic       tb_clk_en,
  output logic       cpu_clk_en,
  output logic       per_clk_en,
  output logic       imask_force,
  output logic [1:0] imask_val,
  output logic       wdg_rst_req,
  output logic       cpu_release,
  output logic [1:0] wake_cause
);
  import lph_pkg::*;
  lph_state_e state_w;
  logic       cnt_clr_w, cnt_en_w, dly_done_w;

  // named internal events for the checker
  logic run_w, ahalt_w, dly_busy_w;
  assign run_w      = is_running(state_w);
  assign ahalt_w    = (state_w == ST_AHALT);
  assign dly_busy_w = (state_w == ST_DELAY);

  lph_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_sel(osc_sel),
    .ext_irq(ext_irq), .tb_irq(tb_irq), .rst_req(rst_req),
    .dly_done(dly_done_w), .state(state_w), .cause(wake_cause),
    .release_pulse(cpu_release), .cnt_clr(cnt_clr_w), .cnt_en(cnt_en_w)
  );

  lph_dly_cnt #(.CNT_W(CNT_W), .SHORT_LEN(SHORT_LEN), .LONG_LEN(LONG_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr_w), .en(cnt_en_w),
    .long_sel(long_dly), .done(dly_done_w)
  );

  lph_gate u_gate (
    .state(state_w), .wdg_en(wdg_en), .osc_en(osc_clk_en), .tb_en(tb_clk_en),
    .cpu_en(cpu_clk_en), .per_en(per_clk_en), .mask_force(imask_force),
    .mask_val(imask_val), .wdg_req(wdg_rst_req)
  );
endmodule

// File: rtl/lph_chk.sv
module lph_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       halt_req,
  input logic       osc_sel,
  input logic       ext_irq,
  input logic       tb_irq,
  input logic       rst_req,
  input logic       osc_clk_en,
  input logic       tb_clk_en,
  input logic       cpu_clk_en,
  input logic       per_clk_en,
  input logic       imask_force,
  input logic [1:0] imask_val,
  input logic       wdg_rst_req,
  input logic       cpu_release,
  input logic [1:0] wake_cause,
  input logic       run_w,
  input logic       ahalt_w,
  input logic       dly_busy_w,
  input logic       dly_done_w
);
  assert_full_halt_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && halt_req && !osc_sel) |=> (!osc_clk_en && !tb_clk_en && !cpu_clk_en && !per_clk_en));

  assert_active_halt_gates_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && halt_req && osc_sel) |=> (osc_clk_en && tb_clk_en && !cpu_clk_en && !per_clk_en));

  assert_irq_wake_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ahalt_w && !rst_req && (ext_irq || tb_irq)) |=> (cpu_clk_en && cpu_release));

  assert_no_early_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_busy_w && !dly_done_w) |=> (!cpu_release && !cpu_clk_en));

  assert_mask_forced_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && halt_req && osc_sel) |=> (imask_force && imask_val == 2'b10));

  assert_no_wdg_in_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ahalt_w |-> !wdg_rst_req);

  assert_reset_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ahalt_w && rst_req) |=> (wake_cause == 2'd3 && !cpu_clk_en));

  assert_cause_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (run_w && halt_req) |=> (wake_cause == 2'd0));
endmodule

bind lph_ctrl_top lph_chk u_chk (
  .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_sel(osc_sel),
  .ext_irq(ext_irq), .tb_irq(tb_irq), .rst_req(rst_req),
  .osc_clk_en(osc_clk_en), .tb_clk_en(tb_clk_en), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .imask_force(imask_force), .imask_val(imask_val),
  .wdg_rst_req(wdg_rst_req), .cpu_release(cpu_release), .wake_cause(wake_cause),
  .run_w(run_w), .ahalt_w(ahalt_w), .dly_busy_w(dly_busy_w), .dly_done_w(dly_done_w)
);

// File: tb/lph_ctrl_top_tb.sv
`timescale 1ns/1ps
module lph_ctrl_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt_req = 0, osc_sel = 0, ext_irq = 0, tb_irq = 0, rst_req = 0;
  logic wdg_en = 0, long_dly = 0;
  logic osc_clk_en, tb_clk_en, cpu_clk_en, per_clk_en, imask_force;
  logic [1:0] imask_val, wake_cause;
  logic wdg_rst_req, cpu_release;

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lph_ctrl_top dut_i (
    .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .osc_sel(osc_sel),
    .ext_irq(ext_irq), .tb_irq(tb_irq), .rst_req(rst_req), .wdg_en(wdg_en),
    .long_dly(long_dly), .osc_clk_en(osc_clk_en), .tb_clk_en(tb_clk_en),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .imask_force(imask_force),
    .imask_val(imask_val), .wdg_rst_req(wdg_rst_req), .cpu_release(cpu_release),
    .wake_cause(wake_cause)
  );

  // behavioural reference: 0 run, 1 full halt, 2 active halt, 3 settle, 4 guard window, 5 idle remainder
  int m_st = 0, m_rem = 0, m_cause = 0, m_rel = 0;

  always @(posedge clk or negedge rst_n) begin
    int len;
    if (!rst_n) begin
      m_st = 0; m_rem = 0; m_cause = 0; m_rel = 0;
    end else begin
      len = long_dly ? 4096 : 256;
      m_rel = 0;
      if (m_st == 0 || m_st == 4) begin
        if (halt_req) begin
          m_cause = 0; m_st = osc_sel ? 2 : 1;
        end else if (m_st == 4) begin
          if (m_rem == 1) m_st = 0;
          else begin
            m_rem--;
            if (!osc_sel) m_st = 5;
          end
        end
      end else if (m_st == 1) begin
        if (rst_req)      begin m_cause = 3; m_st = 3; m_rem = len; end
        else if (ext_irq) begin m_cause = 1; m_st = 3; m_rem = len; end
      end else if (m_st == 2) begin
        if (rst_req)      begin m_cause = 3; m_st = 3; m_rem = len; end
        else if (ext_irq) begin m_cause = 1; m_st = 0; m_rel = 1; end
        else if (tb_irq)  begin m_cause = 2; m_st = 4; m_rem = len; m_rel = 1; end
      end else begin
        if (m_rem == 1) begin m_st = 0; m_rel = 1; end
        else m_rem--;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // per-cycle comparison against the reference, away from the active edge
  always @(negedge clk) begin
    int run_like;
    cycles++;
    run_like = (m_st == 0 || m_st == 4) ? 1 : 0;
    check("R1 clock enables", {osc_clk_en, tb_clk_en, cpu_clk_en, per_clk_en},
          {(run_like || m_st == 2 || m_st == 3) ? 1'b1 : 1'b0,
           (run_like || m_st == 2) ? 1'b1 : 1'b0,
           run_like[0], run_like[0]});
    check("R4 mask", {imask_force, imask_val}, (m_st == 2) ? 3'b110 : 3'b000);
    check("R6 watchdog", wdg_rst_req, (m_st == 1 && wdg_en) ? 1 : 0);
    check("R2 release", cpu_release, m_rel);
    check("R9 cause", wake_cause, m_cause);
    if (cycles > MAX_CYCLES && !finished) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, MAX_CYCLES);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic step(); @(negedge clk); #1; endtask

  task automatic pulse_halt(input logic sel);
    osc_sel = sel; halt_req = 1; step(); halt_req = 0;
  endtask

  // count cycles until the CPU enable comes back
  task automatic wait_run(output int n);
    n = 0;
    while (!cpu_clk_en && n < 10000) begin @(negedge clk); #1; n++; end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset state run", {osc_clk_en, cpu_clk_en, wake_cause}, 4'b1100);
    #1 rst_n = 1;
    step();

    // full halt with watchdog on; timebase ignored; external wake with short settle
    wdg_en = 1;
    pulse_halt(0);
    check("R6 watchdog request in full halt", wdg_rst_req, 1);
    tb_irq = 1; step(); tb_irq = 0; step();
    check("R8 timebase ignored in full halt", {osc_clk_en, cpu_clk_en}, 0);
    ext_irq = 1; step(); ext_irq = 0;
    wait_run(n);
    check("R8 external wake from full halt settles 256", n, 256);
    check("R9 cause external", wake_cause, 1);
    step();

    // active halt, external wake, no delay
    pulse_halt(1);
    check("R1 active halt keeps osc and timebase", {osc_clk_en, tb_clk_en, cpu_clk_en}, 3'b110);
    check("R10 cause cleared on entry", wake_cause, 0);
    check("R6 no watchdog request in active halt", wdg_rst_req, 0);
    step();
    ext_irq = 1; step(); ext_irq = 0;
    check("R2 immediate run after external wake", {cpu_clk_en, cpu_release}, 2'b11);
    step();
    check("R2 release is one cycle", cpu_release, 0);

    // pending interrupt at entry
    ext_irq = 1; osc_sel = 1; halt_req = 1; step(); halt_req = 0;
    check("R5 in active halt for one cycle", {osc_clk_en, cpu_clk_en}, 2'b10);
    step(); ext_irq = 0;
    check("R5 run on next cycle", cpu_clk_en, 1);

    // reset and interrupt together from active halt
    step();
    pulse_halt(1);
    rst_req = 1; ext_irq = 1; step(); rst_req = 0; ext_irq = 0;
    check("R9 reset wins over interrupt", wake_cause, 3);
    wait_run(n);
    check("R3 reset wake short settle 256", n, 256);
    step();

    // timebase wake, select kept: guard window runs out quietly
    pulse_halt(1);
    tb_irq = 1; step(); tb_irq = 0;
    check("R9 cause timebase", wake_cause, 2);
    repeat (300) step();
    check("R7 stays running with select kept", cpu_clk_en, 1);

    // timebase wake, select cleared at offset 11: idle remainder
    pulse_halt(1);
    tb_irq = 1; step(); tb_irq = 0;
    repeat (10) @(negedge clk);
    #1 osc_sel = 0;
    @(negedge clk); #1;
    check("R7 full halt remainder gates all", {osc_clk_en, tb_clk_en, cpu_clk_en, per_clk_en}, 0);
    wait_run(n);
    check("R7 remainder length", n, 245);
    osc_sel = 1;
    step();

    // long option from active halt by reset
    long_dly = 1;
    pulse_halt(1);
    rst_req = 1; step(); rst_req = 0;
    wait_run(n);
    check("R3 reset wake long settle 4096", n, 4096);
    step();

    // long option from full halt by reset
    wdg_en = 0;
    pulse_halt(0);
    check("R6 no request with watchdog off", wdg_rst_req, 0);
    rst_req = 1; step(); rst_req = 0;
    wait_run(n);
    check("R8 reset wake from full halt long 4096", n, 4096);
    repeat (3) step();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule